// File: doc/BRIEF.md
# Byte-Wide Stack Call/Return Sequencer

This block runs the stack side of subroutine linkage on a memory that is one byte wide. It keeps a 16-bit stack pointer and a 16-bit program counter. It takes one of four commands: call, return, push of a register pair, or pop of a register pair. Each command turns into a short run of single-byte memory accesses. The stack grows downward. In every 16-bit value kept on the stack, the more significant byte sits at the higher address.

Commands arrive on a valid/ready interface. The command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is high only while the sequencer is idle, so a command offered while it is busy is held off and has no effect. A popped pair leaves on a second valid/ready interface. `res_valid` and `res_data` stay unchanged until the consumer raises `res_ready`, and the sequencer stays busy until then. The memory port has a write strobe and a read strobe. Read data must come back on the clock edge after the read address is presented, which is one cycle of latency.

The reset values of the stack pointer and program counter are parameters. Stack pointer arithmetic wraps modulo 65536.

Top module: `stack_seq`

## Requirements
- R1: After reset: `busy`=0, `cmd_ready`=1, `res_valid`=0, both memory strobes low, `sp_o`=SP_INIT (default 0x0000) and `pc_o`=PC_INIT (default 0x0100).
- R2: Call (`cmd_op`=2'b00). In the first cycle after acceptance the block writes `pc_o[15:8]` to address SP-1. In the second cycle it writes `pc_o[7:0]` to address SP-2.
- R3: When a call completes, after its two write cycles, `busy` is low, `sp_o` is the old SP minus 2 and `pc_o` holds `cmd_arg`.
- R4: Push (`cmd_op`=2'b10). The block writes `cmd_arg[15:8]` to SP-1 in the first cycle and `cmd_arg[7:0]` to SP-2 in the second cycle. SP then drops by 2 and `pc_o` is unchanged.
- R5: Return (`cmd_op`=2'b01). The block reads address SP in the first cycle and SP+1 in the second cycle. A third cycle makes no memory access. After it, `busy` is low, `pc_o` = {byte at SP+1, byte at SP} and SP has risen by 2.
- R6: Pop (`cmd_op`=2'b11). The reads follow the same pattern as return. After the third cycle, `res_valid`=1 and `res_data` = {byte at SP+1, byte at SP}. SP has risen by 2 and `pc_o` is unchanged.
- R7: While `res_valid` is high and `res_ready` is low, `res_valid` stays high, `res_data` stays stable, `busy` stays high and `cmd_ready` stays low. One cycle after `res_ready` is seen high, the block is idle.
- R8: SP arithmetic and the addresses derived from it wrap modulo 65536. A call at SP=0x0000 writes 0xFFFF and then 0xFFFE. A return at SP=0xFFFE reads 0xFFFE and then 0xFFFF, and leaves SP=0x0000.
- R9: A command offered while `busy` is high is not accepted. It changes no SP, PC or memory contents, and no result.
- R10: The write strobe and the read strobe are never high together, and both are low whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken (idle) |
| cmd_op | input | 2 | 00 call, 01 return, 10 push, 11 pop |
| cmd_arg | input | 16 | Call target or pair value to push |
| res_valid | output | 1 | Popped pair available |
| res_ready | input | 1 | Consumer takes the popped pair |
| res_data | output | 16 | Popped pair, high byte from higher address |
| busy | output | 1 | Sequence in progress |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, one cycle after address |
| sp_o | output | 16 | Current stack pointer |
| pc_o | output | 16 | Current program counter |

## Verification
A wrong sequencing state shows on the memory port within the first or second cycle after a command is accepted. The address is off by one, the byte lanes are swapped, or a strobe is missing or present at the wrong time. A wrong SP or PC update shows on `sp_o`/`pc_o` in the cycle after `busy` falls. It also shows later, when a return or pop reads back from the wrong place. A bad capture of the returned bytes shows at once in `pc_o` or `res_data` with its byte halves crossed. A broken result handshake shows as `res_valid` dropping, or the data changing, while `res_ready` is low.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;

  typedef enum logic [1:0] {
    OP_CALL = 2'b00,
    OP_RET  = 2'b01,
    OP_PUSH = 2'b10,
    OP_POP  = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_HI,
    ST_WR_LO,
    ST_RD_LO,
    ST_RD_HI,
    ST_CAP,
    ST_RESULT
  } state_e;

  function automatic logic op_writes(op_e op);
    return (op == OP_CALL) || (op == OP_PUSH);
  endfunction

endpackage

// File: rtl/ss_fsm.sv
module ss_fsm
  import stack_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [1:0] op_in,
  input  logic       res_ready,
  output state_e     state,
  output op_e        op_q
);

  state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:   if (start) nxt = op_writes(op_e'(op_in)) ? ST_WR_HI : ST_RD_LO;
      ST_WR_HI:  nxt = ST_WR_LO;
      ST_WR_LO:  nxt = ST_IDLE;
      ST_RD_LO:  nxt = ST_RD_HI;
      ST_RD_HI:  nxt = ST_CAP;
      ST_CAP:    nxt = (op_q == OP_POP) ? ST_RESULT : ST_IDLE;
      ST_RESULT: if (res_ready) nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      op_q  <= OP_CALL;
    end else begin
      state <= nxt;
      if (start) op_q <= op_e'(op_in);
    end
  end

endmodule

// File: rtl/ss_port.sv
module ss_port
  import stack_seq_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W
) (
  input  state_e              state,
  input  op_e                 op_q,
  input  logic [WORD_W-1:0]   sp,
  input  logic [WORD_W-1:0]   pc,
  input  logic [WORD_W-1:0]   arg_q,
  output logic                mem_we,
  output logic                mem_re,
  output logic [WORD_W-1:0]   mem_addr,
  output logic [BYTE_W-1:0]   mem_wdata
);

  localparam logic [WORD_W-1:0] ONE = WORD_W'(1);
  localparam logic [WORD_W-1:0] TWO = WORD_W'(2);

  logic [WORD_W-1:0] src;
  logic [BYTE_W-1:0] lane [2];

  assign src = (op_q == OP_CALL) ? pc : arg_q;

  for (genvar i = 0; i < 2; i++) begin : g_lane
    assign lane[i] = src[i*BYTE_W +: BYTE_W];
  end

  always_comb begin
    mem_we    = 1'b0;
    mem_re    = 1'b0;
    mem_addr  = sp;
    mem_wdata = '0;
    unique case (state)
      ST_WR_HI: begin
        mem_we    = 1'b1;
        mem_addr  = sp - ONE;
        mem_wdata = lane[1];
      end
      ST_WR_LO: begin
        mem_we    = 1'b1;
        mem_addr  = sp - TWO;
        mem_wdata = lane[0];
      end
      ST_RD_LO: begin
        mem_re   = 1'b1;
        mem_addr = sp;
      end
      ST_RD_HI: begin
        mem_re   = 1'b1;
        mem_addr = sp + ONE;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/ss_regs.sv
module ss_regs
  import stack_seq_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W,
  parameter logic [WORD_W-1:0] SP_INIT = '0,
  parameter logic [WORD_W-1:0] PC_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] cmd_arg,
  input  state_e            state,
  input  op_e               op_q,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] sp,
  output logic [WORD_W-1:0] pc,
  output logic [WORD_W-1:0] arg_q,
  output logic [WORD_W-1:0] res_q
);

  localparam logic [WORD_W-1:0] TWO = WORD_W'(2);

  logic [BYTE_W-1:0] lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp    <= SP_INIT;
      pc    <= PC_INIT;
      arg_q <= '0;
      res_q <= '0;
      lo_q  <= '0;
    end else begin
      if (start) arg_q <= cmd_arg;
      unique case (state)
        ST_WR_LO: begin
          sp <= sp - TWO;
          if (op_q == OP_CALL) pc <= arg_q;
        end
        ST_RD_HI: lo_q <= mem_rdata;
        ST_CAP: begin
          sp <= sp + TWO;
          if (op_q == OP_RET) pc <= {mem_rdata, lo_q};
          else res_q <= {mem_rdata, lo_q};
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stack_seq_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int WORD_W = 2 * BYTE_W,
  parameter logic [WORD_W-1:0] SP_INIT = 16'h0000,
  parameter logic [WORD_W-1:0] PC_INIT = 16'h0100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [WORD_W-1:0] cmd_arg,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [WORD_W-1:0] res_data,
  output logic              busy,
  output logic              mem_we,
  output logic              mem_re,
  output logic [WORD_W-1:0] mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [WORD_W-1:0] sp_o,
  output logic [WORD_W-1:0] pc_o
);

  state_e            state;
  op_e               op_q;
  logic              start;
  logic [WORD_W-1:0] arg_q;

  assign cmd_ready = (state == ST_IDLE);
  assign start     = cmd_valid && cmd_ready;
  assign busy      = (state != ST_IDLE);
  assign res_valid = (state == ST_RESULT);

  ss_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op_in     (cmd_op),
    .res_ready (res_ready),
    .state     (state),
    .op_q      (op_q)
  );

  ss_regs #(.BYTE_W(BYTE_W), .SP_INIT(SP_INIT), .PC_INIT(PC_INIT)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cmd_arg   (cmd_arg),
    .state     (state),
    .op_q      (op_q),
    .mem_rdata (mem_rdata),
    .sp        (sp_o),
    .pc        (pc_o),
    .arg_q     (arg_q),
    .res_q     (res_data)
  );

  ss_port #(.BYTE_W(BYTE_W)) u_port (
    .state     (state),
    .op_q      (op_q),
    .sp        (sp_o),
    .pc        (pc_o),
    .arg_q     (arg_q),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata)
  );

endmodule

// File: rtl/ss_chk.sv
module ss_chk #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              mem_we,
  input logic              mem_re,
  input logic [WORD_W-1:0] mem_addr,
  input logic [WORD_W-1:0] sp_o,
  input logic              res_valid,
  input logic              res_ready,
  input logic [WORD_W-1:0] res_data
);

  localparam logic [WORD_W-1:0] ONE = WORD_W'(1);
  localparam logic [WORD_W-1:0] TWO = WORD_W'(2);

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we, mem_re}) && (busy || (!mem_we && !mem_re)));

  // R2
  wr_descend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - ONE));

  // R5
  rd_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && $past(mem_re)) |-> (mem_addr == $past(mem_addr) + ONE));

  // R3
  sp_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(busy) && $past(mem_we)) |-> (sp_o == $past(sp_o) - TWO));

  // R7
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && busy && $stable(res_data)));

endmodule

bind stack_seq ss_chk #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .mem_we    (mem_we),
  .mem_re    (mem_re),
  .mem_addr  (mem_addr),
  .sp_o      (sp_o),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_data  (res_data)
);

// File: tb/sim_stack_seq.sv
`timescale 1ns/1ps
module sim_stack_seq;

  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        cmd_valid = 0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 0;
  logic [15:0] cmd_arg = 0;
  logic        res_valid;
  logic        res_ready = 0;
  logic [15:0] res_data;
  logic        busy;
  logic        mem_we, mem_re;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = 0;
  logic [15:0] sp_o, pc_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  logic [15:0] sp_m, pc_m;
  logic [7:0]  mem [logic [15:0]];

  always #(CLK_PERIOD/2) clk = ~clk;

  stack_seq u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_arg(cmd_arg), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .busy(busy), .mem_we(mem_we), .mem_re(mem_re),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .sp_o(sp_o), .pc_o(pc_o)
  );

  function automatic logic [7:0] rd_byte(logic [15:0] a);
    if (mem.exists(a)) return mem[a];
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] = mem_wdata;
    if (mem_re) mem_rdata <= rd_byte(mem_addr);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected <150000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  // One command with optional injection of a rival command while busy (R9)
  // and a random hold time on the result interface (R7).
  task automatic run_cmd(input logic [1:0] op, input logic [15:0] arg,
                         input bit inject, input int hold);
    logic [15:0] exp_w;
    @(negedge clk);
    chk(cmd_ready && !busy, "R9", "ready before cmd", {cmd_ready, busy}, 2'b10);
    cmd_valid = 1; cmd_op = op; cmd_arg = arg;
    @(negedge clk);
    cmd_valid = inject; cmd_op = 2'(~op); cmd_arg = ~arg;
    if (op == 2'b00 || op == 2'b10) begin
      exp_w = (op == 2'b00) ? pc_m : arg;
      chk(mem_we && !mem_re && mem_addr == sp_m - 16'd1 && mem_wdata == exp_w[15:8],
          op == 2'b00 ? "R2" : "R4", "hi write", {mem_addr, mem_wdata}, {sp_m - 16'd1, exp_w[15:8]});
      chk(!cmd_ready, "R9", "ready while busy", cmd_ready, 0);
      @(negedge clk);
      cmd_valid = 0;
      chk(mem_we && mem_addr == sp_m - 16'd2 && mem_wdata == exp_w[7:0],
          op == 2'b00 ? "R2" : "R4", "lo write", {mem_addr, mem_wdata}, {sp_m - 16'd2, exp_w[7:0]});
      sp_m = sp_m - 16'd2;
      if (op == 2'b00) pc_m = arg;
      @(negedge clk);
      chk(!busy && sp_o == sp_m && pc_o == pc_m, op == 2'b00 ? "R3" : "R4",
          "sp/pc after write", {sp_o, pc_o}, {sp_m, pc_m});
    end else begin
      exp_w = {rd_byte(sp_m + 16'd1), rd_byte(sp_m)};
      chk(mem_re && !mem_we && mem_addr == sp_m, "R5", "first read addr", mem_addr, sp_m);
      @(negedge clk);
      chk(mem_re && mem_addr == sp_m + 16'd1, "R5", "second read addr", mem_addr, sp_m + 16'd1);
      @(negedge clk);
      chk(busy && !mem_re && !mem_we, "R10", "idle mem in capture", {mem_re, mem_we}, 0);
      if (op == 2'b01) cmd_valid = 0;
      sp_m = sp_m + 16'd2;
      if (op == 2'b01) pc_m = exp_w;
      @(negedge clk);
      if (op == 2'b01) begin
        chk(!busy && pc_o == pc_m && sp_o == sp_m, "R5", "pc/sp after return",
            {pc_o, sp_o}, {pc_m, sp_m});
      end else begin
        chk(res_valid && res_data == exp_w && sp_o == sp_m && pc_o == pc_m, "R6",
            "pop result", {res_data, sp_o}, {exp_w, sp_m});
        for (int i = 0; i < hold; i++) begin
          @(negedge clk);
          chk(res_valid && busy && !cmd_ready && res_data == exp_w && sp_o == sp_m, "R7",
              "result held", {res_valid, res_data}, {1'b1, exp_w});
        end
        res_ready = 1; cmd_valid = 0;
        @(negedge clk);
        res_ready = 0;
        chk(!busy && !res_valid && sp_o == sp_m, "R7", "idle after take",
            {busy, res_valid}, 0);
      end
    end
  endtask

  initial begin
    sp_m = 16'h0000;
    pc_m = 16'h0100;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && cmd_ready && !res_valid && !mem_we && !mem_re, "R1", "idle after reset",
        {busy, cmd_ready, res_valid, mem_we, mem_re}, 5'b01000);
    chk(sp_o == 16'h0000 && pc_o == 16'h0100, "R1", "reset sp/pc", {sp_o, pc_o}, 32'h00000100);

    // R8: wrap downward then upward
    run_cmd(2'b00, 16'h1234, 0, 0);
    chk(sp_o == 16'hFFFE && mem[16'hFFFF] == 8'h01 && mem[16'hFFFE] == 8'h00, "R8",
        "wrap on call", {sp_o, mem[16'hFFFF], mem[16'hFFFE]}, {16'hFFFE, 16'h0100});
    run_cmd(2'b01, 16'h0000, 1, 0);
    chk(sp_o == 16'h0000 && pc_o == 16'h0100, "R8", "wrap on return", {sp_o, pc_o}, 32'h00000100);

    // push/pop pair with a held result and a rival command (R9, R7)
    run_cmd(2'b10, 16'hA55A, 1, 0);
    run_cmd(2'b11, 16'h0000, 1, 3);
    chk(pc_o == 16'h0100, "R6", "pc unchanged by pop", pc_o, 16'h0100);

    // random traffic
    for (int k = 0; k < 400; k++) begin
      logic [1:0] op;
      op = 2'($urandom % 4);
      run_cmd(op, 16'($urandom), 1'($urandom % 2), int'($urandom % 4));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
  end

endmodule